// File: doc/BRIEF.md
# I3C Target Status Byte

This block holds the one-byte status word of an I3C/I2C target controller. The bus engine feeds it two kinds of signal. Levels are bus idle, target protocol mode, bus data-rate mode, transmit-slot empty and receive-slot full. Pulses are reset-pattern seen, transfer acknowledged (with its kind and direction) and target gone idle. Software reads the byte through a plain register port. It can also write the two fields that accept writes: the sticky reset-pattern flag and the transfer-direction field.

Software writes take priority over hardware events that arrive in the same cycle. The direction field only records acknowledged private transfers and legacy I2C transfers; broadcast commands, in-band interrupts and hot-join are ignored. While the device sleeps, no hardware update reaches the byte. After wake, updates stay frozen until a set number of instruction-cycle ticks (default two) have arrived. On the clock edge that samples the last of those ticks, the byte reloads the current levels.

All pins are plain control and status pins with no stream interface, so no back-pressure rules apply.

Top module: `i3c_tgt_status`

## Requirements
- R1: After reset, rd_data_o reads 8'h88.
- R2: When updates are enabled, bit 7 follows bus_free_i, bit 6 follows mode_i3c_i (1 = I3C, 0 = legacy I2C), bit 5 follows mode_hdr_i (1 = HDR, 0 = SDR), bit 3 follows tx_empty_i and bit 2 follows rx_full_i, each one clock later.
- R3: A write through reg_wr_i leaves bits 7, 6, 5, 3 and 2 unchanged.
- R4: Bit 4 is set by a rst_pat_i pulse and stays set until software writes 0 to it. A write loads bit 4 from reg_wdata_i[4].
- R5: A pulse on xfer_ack_i with xfer_kind_i of 2'b00 (private) or 2'b01 (legacy I2C) loads bits 1:0 with 2'b01 if xfer_rd_i is 1 (controller read), or with 2'b10 if it is 0 (controller write).
- R6: An acknowledge with xfer_kind_i of 2'b10 (broadcast command) or 2'b11 (in-band interrupt or hot-join) leaves bits 1:0 unchanged.
- R7: A pulse on idle_i clears bits 1:0 to 2'b00. A capturing acknowledge in the same cycle wins over idle_i.
- R8: A write clears each bit of 1:0 where reg_wdata_i holds 0 and leaves it as it was where reg_wdata_i holds 1. Software never sets these bits.
- R9: In a cycle with reg_wr_i high, hardware events do not act on bit 4 or bits 1:0; only the write does.
- R10: Bits 1:0 never read 2'b11.
- R11: While sleep_i is high, and after it falls until the wake reload, no hardware input changes the byte. Events that arrive in that window are dropped.
- R12: After sleep_i falls, the byte reloads on the clock edge that samples the second tick_i pulse, and it follows its inputs again from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle tick pulse |
| sleep_i | input | 1 | Device sleep level |
| bus_free_i | input | 1 | Bus idle level |
| mode_i3c_i | input | 1 | Target in I3C mode (0: legacy I2C) |
| mode_hdr_i | input | 1 | Bus in HDR mode (0: SDR) |
| tx_empty_i | input | 1 | Transmit slot empty level |
| rx_full_i | input | 1 | Receive slot full level |
| rst_pat_i | input | 1 | Target reset pattern seen, pulse |
| xfer_ack_i | input | 1 | Transfer acknowledged by target, pulse |
| xfer_kind_i | input | 2 | Transfer kind: 00 private, 01 legacy I2C, 10 broadcast command, 11 interrupt or hot-join |
| xfer_rd_i | input | 1 | Acknowledged transfer is a controller read |
| idle_i | input | 1 | Target returned to idle, pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Status byte |

## Verification
The direction field is driven with all four transfer kinds, crossed with both directions, each alone and together with an idle pulse and with a write. This separates capture from filtering, and shows which side wins when an acknowledge and an idle pulse collide. Collision patterns place a reset-pattern pulse in the same cycle as a write of 0, and a write of 1 to a read-only bit, to show software priority and read-only masking. A sleep window carries level changes and event pulses, then ticks are spaced across several idle cycles after wake. This shows that nothing leaks in early and that the reload lands on exactly the second tick. A seeded random phase mixes all of these inputs against a bench model built from the requirements.

// File: rtl/i3cst_pkg.sv
package i3cst_pkg;
  localparam int STAT_W = 8;
  localparam int LVL_N  = 5;

  // level vector order: bus free, i3c mode, hdr mode, tx empty, rx full
  localparam logic [LVL_N-1:0] LVL_RST = 5'b10010;

  typedef enum logic [1:0] {
    XK_PRIV   = 2'b00,
    XK_LEGACY = 2'b01,
    XK_CCC    = 2'b10,
    XK_IBI_HJ = 2'b11
  } xfer_kind_e;

  localparam logic [1:0] DIR_IDLE = 2'b00;
  localparam logic [1:0] DIR_RD   = 2'b01;
  localparam logic [1:0] DIR_WR   = 2'b10;
endpackage

// File: rtl/i3cst_wake_gate.sv
module i3cst_wake_gate #(
  parameter int WAKE_TICKS = 2,
  localparam int CW = $clog2(WAKE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic tick_i,
  output logic hw_en_o
);
  logic          frozen_q;
  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = tick_i && (cnt_q == CW'(WAKE_TICKS - 1));
  assign hw_en_o   = !sleep_i && (!frozen_q || last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      cnt_q    <= '0;
    end else if (sleep_i) begin
      frozen_q <= 1'b1;
      cnt_q    <= '0;
    end else if (frozen_q && tick_i) begin
      if (last_tick) begin
        frozen_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R12: the count of ticks seen while frozen stays below the limit
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WAKE_TICKS));
  // R11: a sleeping cycle always leaves the gate frozen
  p_sleep_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> frozen_q);
endmodule

// File: rtl/i3cst_level_bits.sv
module i3cst_level_bits #(
  parameter int NL = 5,
  parameter logic [NL-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en_i,
  input  logic [NL-1:0] lvl_i,
  output logic [NL-1:0] lvl_q
);
  for (genvar g = 0; g < NL; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q[g] <= RST_VAL[g];
      else if (hw_en_i) lvl_q[g] <= lvl_i[g];
    end
  end

  // R2: an enabled cycle makes the stored levels match the sampled inputs
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en_i |=> lvl_q == $past(lvl_i));
endmodule

// File: rtl/i3cst_event_bits.sv
module i3cst_event_bits
  import i3cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_en_i,
  input  logic       sw_wr_i,
  input  logic       sw_rstdet_i,
  input  logic [1:0] sw_dir_keep_i,
  input  logic       rst_pat_i,
  input  logic       ack_i,
  input  xfer_kind_e kind_i,
  input  logic       rd_i,
  input  logic       idle_i,
  output logic       rstdet_q,
  output logic [1:0] dir_q
);
  logic capture;
  assign capture = ack_i && (kind_i == XK_PRIV || kind_i == XK_LEGACY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rstdet_q <= 1'b0;
    else if (sw_wr_i)               rstdet_q <= sw_rstdet_i;
    else if (hw_en_i && rst_pat_i)  rstdet_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   dir_q <= DIR_IDLE;
    else if (sw_wr_i)             dir_q <= dir_q & sw_dir_keep_i;
    else if (hw_en_i && capture)  dir_q <= rd_i ? DIR_RD : DIR_WR;
    else if (hw_en_i && idle_i)   dir_q <= DIR_IDLE;
  end

  // R10: reserved direction code is never held
  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q != 2'b11);
  // R4: flag stays set without a write
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rstdet_q && !sw_wr_i) |=> rstdet_q);
  // R9: a write decides the flag regardless of a same-cycle pattern pulse
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> rstdet_q == $past(sw_rstdet_i));
  // R6: filtered kinds leave direction alone
  p_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && kind_i[1] && !idle_i && !sw_wr_i) |=> $stable(dir_q));
  // R8: software never raises a direction bit
  p_sw_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> (dir_q & ~$past(dir_q)) == 2'b00);
endmodule

// File: rtl/i3c_tgt_status.sv
module i3c_tgt_status
  import i3cst_pkg::*;
#(
  parameter int WAKE_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        sleep_i,
  input  logic        bus_free_i,
  input  logic        mode_i3c_i,
  input  logic        mode_hdr_i,
  input  logic        tx_empty_i,
  input  logic        rx_full_i,
  input  logic        rst_pat_i,
  input  logic        xfer_ack_i,
  input  logic [1:0]  xfer_kind_i,
  input  logic        xfer_rd_i,
  input  logic        idle_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  rd_data_o
);
  logic             hw_en;
  logic [LVL_N-1:0] lvl_q;
  logic             rstdet_q;
  logic [1:0]       dir_q;

  i3cst_wake_gate #(.WAKE_TICKS(WAKE_TICKS)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (sleep_i),
    .tick_i  (tick_i),
    .hw_en_o (hw_en)
  );

  i3cst_level_bits #(.NL(LVL_N), .RST_VAL(LVL_RST)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_en_i (hw_en),
    .lvl_i   ({bus_free_i, mode_i3c_i, mode_hdr_i, tx_empty_i, rx_full_i}),
    .lvl_q   (lvl_q)
  );

  i3cst_event_bits u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_en_i       (hw_en),
    .sw_wr_i       (reg_wr_i),
    .sw_rstdet_i   (reg_wdata_i[4]),
    .sw_dir_keep_i (reg_wdata_i[1:0]),
    .rst_pat_i     (rst_pat_i),
    .ack_i         (xfer_ack_i),
    .kind_i        (xfer_kind_e'(xfer_kind_i)),
    .rd_i          (xfer_rd_i),
    .idle_i        (idle_i),
    .rstdet_q      (rstdet_q),
    .dir_q         (dir_q)
  );

  assign rd_data_o = {lvl_q[4], lvl_q[3], lvl_q[2], rstdet_q,
                      lvl_q[1], lvl_q[0], dir_q};

  // R11: a sleeping cycle changes no read-only bit
  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ({rd_data_o[7:5], rd_data_o[3:2]} ==
                 $past({rd_data_o[7:5], rd_data_o[3:2]})));
  // R11: in sleep without a write the whole byte holds
  p_sleep_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !reg_wr_i) |=> rd_data_o == $past(rd_data_o));
endmodule

// File: tb/i3c_tgt_status_bench.sv
module i3c_tgt_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, sleep_i = 0, bus_free_i = 1, mode_i3c_i = 0, mode_hdr_i = 0;
  logic tx_empty_i = 1, rx_full_i = 0, rst_pat_i = 0, xfer_ack_i = 0;
  logic [1:0] xfer_kind_i = 0;
  logic xfer_rd_i = 0, idle_i = 0, reg_wr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] rd_data_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i3c_tgt_status u_i3c_tgt_status (.*);

  // bench model from the requirements
  logic [7:0] exp_q;
  logic frz_q;
  int tcnt_q;

  function automatic logic en_now(logic frz, int tc);
    return !sleep_i && (!frz || (tick_i && tc == 1));
  endfunction

  function automatic logic [7:0] next_val(logic [7:0] cur, logic en);
    logic [7:0] n = cur;
    if (en) begin
      n[7] = bus_free_i; n[6] = mode_i3c_i; n[5] = mode_hdr_i;
      n[3] = tx_empty_i; n[2] = rx_full_i;
    end
    if (reg_wr_i) begin
      n[4] = reg_wdata_i[4];
      n[1:0] = cur[1:0] & reg_wdata_i[1:0];
    end else if (en) begin
      if (rst_pat_i) n[4] = 1'b1;
      if (xfer_ack_i && !xfer_kind_i[1]) n[1:0] = xfer_rd_i ? 2'b01 : 2'b10;
      else if (idle_i) n[1:0] = 2'b00;
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 8'h88; frz_q <= 0; tcnt_q <= 0;
    end else begin
      exp_q <= next_val(exp_q, en_now(frz_q, tcnt_q));
      if (sleep_i) begin frz_q <= 1; tcnt_q <= 0; end
      else if (frz_q && tick_i) begin
        if (tcnt_q == 1) begin frz_q <= 0; tcnt_q <= 0; end
        else tcnt_q <= tcnt_q + 1;
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clr_pulses();
    rst_pat_i = 0; xfer_ack_i = 0; idle_i = 0; reg_wr_i = 0; tick_i = 0;
  endtask

  // inputs set at a negedge; one edge later compare to the model
  task automatic step(string req);
    @(posedge clk); @(negedge clk);
    check(req, rd_data_o, exp_q);
    clr_pulses();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data_o, 8'h88);
    rst_n = 1;
    @(negedge clk);
    step("R1 idle hold");
    check("R1 const", rd_data_o, 8'h88);

    // R2 levels
    bus_free_i = 0; mode_i3c_i = 1; mode_hdr_i = 1; tx_empty_i = 0; rx_full_i = 1;
    step("R2 levels");
    check("R2 const", rd_data_o, 8'b0110_0100);

    // R3 read-only bits ignore writes
    reg_wr_i = 1; reg_wdata_i = 8'b1001_1100;
    step("R3 ro write");
    check("R3 const", rd_data_o & 8'hEC, 8'b0110_0100);

    // R4 sticky flag
    reg_wr_i = 1; reg_wdata_i = 8'h00; step("R4 clear");
    rst_pat_i = 1; step("R4 set");
    check("R4 bit", {7'd0, rd_data_o[4]}, 8'd1);
    repeat (3) step("R4 hold");
    check("R4 still", {7'd0, rd_data_o[4]}, 8'd1);
    reg_wr_i = 1; reg_wdata_i = 8'h00; step("R4 sw clear");
    check("R4 cleared", {7'd0, rd_data_o[4]}, 8'd0);

    // R9 collision: pattern pulse vs write of 0
    rst_pat_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h03; step("R9 collide");
    check("R9 bit", {7'd0, rd_data_o[4]}, 8'd0);

    // R5 capture both directions, both capturing kinds
    xfer_ack_i = 1; xfer_kind_i = 2'b00; xfer_rd_i = 0; step("R5 priv wr");
    check("R5 wr", {6'd0, rd_data_o[1:0]}, 8'd2);
    xfer_ack_i = 1; xfer_kind_i = 2'b01; xfer_rd_i = 1; step("R5 i2c rd");
    check("R5 rd", {6'd0, rd_data_o[1:0]}, 8'd1);

    // R6 filtered kinds
    xfer_ack_i = 1; xfer_kind_i = 2'b10; xfer_rd_i = 0; step("R6 ccc");
    check("R6 ccc", {6'd0, rd_data_o[1:0]}, 8'd1);
    xfer_ack_i = 1; xfer_kind_i = 2'b11; xfer_rd_i = 0; step("R6 ibi");
    check("R6 ibi", {6'd0, rd_data_o[1:0]}, 8'd1);

    // R7 idle clears; ack beats idle
    idle_i = 1; step("R7 idle");
    check("R7 idle", {6'd0, rd_data_o[1:0]}, 8'd0);
    idle_i = 1; xfer_ack_i = 1; xfer_kind_i = 2'b00; xfer_rd_i = 0; step("R7 ack wins");
    check("R7 ack", {6'd0, rd_data_o[1:0]}, 8'd2);

    // R8 write 1 keeps, write 0 clears; R9 write beats ack
    reg_wr_i = 1; reg_wdata_i = 8'h03; step("R8 keep");
    check("R8 keep", {6'd0, rd_data_o[1:0]}, 8'd2);
    reg_wr_i = 1; reg_wdata_i = 8'h01; xfer_ack_i = 1; xfer_kind_i = 2'b00; xfer_rd_i = 1;
    step("R9 wr vs ack");
    check("R8 cleared", {6'd0, rd_data_o[1:0]}, 8'd0);

    // R11 / R12 sleep and wake reload
    bus_free_i = 1; mode_i3c_i = 0; mode_hdr_i = 0; tx_empty_i = 1; rx_full_i = 0;
    step("R2 back");
    sleep_i = 1; step("R11 enter");
    bus_free_i = 0; rx_full_i = 1; rst_pat_i = 1; xfer_ack_i = 1; xfer_kind_i = 0;
    step("R11 asleep");
    check("R11 const", rd_data_o, 8'h88);
    tick_i = 1; step("R11 tick asleep");
    sleep_i = 0; step("R11 woke");
    step("R11 no tick");
    tick_i = 1; rst_pat_i = 1; step("R11 first tick");
    check("R11 frozen", rd_data_o, 8'h88);
    step("R12 gap");
    tick_i = 1; step("R12 second tick");
    check("R12 reload", rd_data_o, 8'b0000_1100);
    bus_free_i = 1; step("R12 follows");
    check("R12 follow", {7'd0, rd_data_o[7]}, 8'd1);

    // random phase: R2 R4 R5 R6 R7 R8 R9 R10 R11 R12 vs model
    for (int i = 0; i < 400; i++) begin
      bus_free_i = $urandom_range(1); mode_i3c_i = $urandom_range(1);
      mode_hdr_i = $urandom_range(1); tx_empty_i = $urandom_range(1);
      rx_full_i = $urandom_range(1);
      rst_pat_i = ($urandom_range(7) == 0);
      xfer_ack_i = ($urandom_range(3) == 0);
      xfer_kind_i = 2'($urandom_range(3)); xfer_rd_i = $urandom_range(1);
      idle_i = ($urandom_range(5) == 0);
      reg_wr_i = ($urandom_range(7) == 0); reg_wdata_i = 8'($urandom);
      tick_i = ($urandom_range(2) == 0);
      if ($urandom_range(15) == 0) sleep_i = ~sleep_i;
      step("R10 R11 R12 random");
      if (rd_data_o[1:0] == 2'b11) check("R10 reserved", rd_data_o, exp_q);
    end
    finish_run();
  end
endmodule